// File: doc/BRIEF.md
# Bang-Bang Optical Power Loop Filter

This block is the digital integrator of an automatic optical power control loop. An analog comparator reports once per sample strobe (nominally 512 kHz) whether the scaled photodiode feedback is below the target level. The block groups these one-bit votes into windows of N strobes. At the end of each window it moves a 10-bit bias DAC code by a single LSB toward the balance point, or leaves it alone.

While the loop is disabled, the code register follows a preload value. Outside logic picks that value from a temperature reading, so the loop starts close to its final value and settles sooner. Each change of the code produces a one-cycle pulse so that downstream logic can capture the new value.

Top module: `apc_loop_filter`

## Requirements
- R1: While `rst_n` is low, `dac_code` is 0 and `code_upd` is 0.
- R2: While `enable` is low, `dac_code` takes the value of `init_code` at every clock edge, and strobes do not change the code.
- R3: A vote with `fb_below`=1 (feedback below target) counts +1 (up). A vote with `fb_below`=0 (feedback at or above target) counts -1 (down).
- R4: A window is N = `ratio_sel`+1 strobes sampled while `enable` is high (N from 1 to 16). `dac_code` can change only at the edge that samples the Nth strobe of a window.
- R5: At a window's end a positive net vote gives +1, a negative net vote gives -1, and a zero net vote leaves the code unchanged.
- R6: While enabled, `dac_code` changes by at most one LSB per clock.
- R7: The code saturates at 0 and at 1023 and never wraps.
- R8: `ratio_sel` is captured while `enable` is low and at each window end. A change made mid-window applies from the following window.
- R9: `code_upd` is high during exactly the cycle after each edge at which `dac_code` changed, and low otherwise.
- R10: Cycles with `sample_stb` low are not counted, whatever `fb_below` does. Integration restarts from an empty window each time `enable` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Loop run control; low holds the preload |
| sample_stb | input | 1 | One-cycle comparator sample strobe |
| fb_below | input | 1 | Comparator decision, 1 = feedback below target |
| ratio_sel | input | 4 | Decimation factor minus one |
| init_code | input | 10 | Temperature-selected preload code |
| dac_code | output | 10 | Bias DAC code |
| code_upd | output | 1 | Pulse marking a new code |

## Verification
The hardest condition to reach is a change of the decimation factor in the middle of a window, combined with votes that net to zero or to plus or minus one, because the window length in force is not visible at the ports. The bench changes `ratio_sel` a few strobes into a window. It then predicts the edge of the next code step from the old length, and the step after that from the new one. Every 16-vote pattern of a length-4 window and every ratio under balanced and one-sided streams are swept, and preloads next to both rails drive the saturation boundaries.

// File: rtl/apc_lf_pkg.sv
package apc_lf_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  // sign of a window's net vote sets the step direction
  function automatic step_e dir_of(input int net);
    if (net > 0)      return STEP_UP;
    else if (net < 0) return STEP_DOWN;
    else              return STEP_HOLD;
  endfunction
endpackage

// File: rtl/apc_lf_decim.sv
module apc_lf_decim
  import apc_lf_pkg::*;
#(
  parameter int RATIO_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               strobe,
  input  logic               vote_up,
  input  logic [RATIO_W-1:0] ratio_sel,
  output logic               win_end,
  output step_e              win_dir
);
  localparam int ACC_W = RATIO_W + 2;
  localparam logic signed [ACC_W-1:0] VOTE_P = ACC_W'(1);
  localparam logic signed [ACC_W-1:0] VOTE_M = -ACC_W'(1);

  logic [RATIO_W-1:0]      cnt_q;
  logic [RATIO_W-1:0]      last_q;
  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] acc_sum;

  assign acc_sum = acc_q + (vote_up ? VOTE_P : VOTE_M);
  assign win_end = enable && strobe && (cnt_q == last_q);
  assign win_dir = win_end ? dir_of(int'(acc_sum)) : STEP_HOLD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      last_q <= '0;
      acc_q  <= '0;
    end else if (!enable) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      last_q <= ratio_sel;
    end else if (strobe) begin
      if (cnt_q == last_q) begin
        cnt_q  <= '0;
        acc_q  <= '0;
        last_q <= ratio_sel;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        acc_q <= acc_sum;
      end
    end
  end
endmodule

// File: rtl/apc_lf_stepper.sv
module apc_lf_stepper
  import apc_lf_pkg::*;
#(
  parameter int CODE_W = 10
) (
  input  logic [CODE_W-1:0] code_cur,
  input  step_e             dir,
  output logic [CODE_W-1:0] code_step
);
  localparam logic [CODE_W-1:0] TOP = '1;

  function automatic logic [CODE_W-1:0] sat_step(input logic [CODE_W-1:0] c,
                                                 input step_e d);
    case (d)
      STEP_UP:   return (c == TOP) ? c : c + 1'b1;
      STEP_DOWN: return (c == '0)  ? c : c - 1'b1;
      default:   return c;
    endcase
  endfunction

  assign code_step = sat_step(code_cur, dir);
endmodule

// File: rtl/apc_lf_code_reg.sv
module apc_lf_code_reg #(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [CODE_W-1:0] preload,
  input  logic [CODE_W-1:0] code_step,
  output logic [CODE_W-1:0] code_q,
  output logic              code_moved,
  output logic              upd_q
);
  logic [CODE_W-1:0] code_d;

  assign code_d     = enable ? code_step : preload;
  assign code_moved = (code_d != code_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      code_q <= code_d;
      upd_q  <= code_moved;
    end
  end
endmodule

// File: rtl/apc_loop_filter.sv
module apc_loop_filter
  import apc_lf_pkg::*;
#(
  parameter int CODE_W  = 10,
  parameter int RATIO_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               sample_stb,
  input  logic               fb_below,
  input  logic [RATIO_W-1:0] ratio_sel,
  input  logic [CODE_W-1:0]  init_code,
  output logic [CODE_W-1:0]  dac_code,
  output logic               code_upd
);
  logic              win_end;
  step_e             win_dir;
  logic [CODE_W-1:0] code_step;
  logic              code_moved;

  apc_lf_decim #(.RATIO_W(RATIO_W)) u_decim (
    .clk(clk), .rst_n(rst_n), .enable(enable), .strobe(sample_stb),
    .vote_up(fb_below), .ratio_sel(ratio_sel),
    .win_end(win_end), .win_dir(win_dir)
  );

  apc_lf_stepper #(.CODE_W(CODE_W)) u_step (
    .code_cur(dac_code), .dir(win_dir), .code_step(code_step)
  );

  apc_lf_code_reg #(.CODE_W(CODE_W)) u_code (
    .clk(clk), .rst_n(rst_n), .enable(enable), .preload(init_code),
    .code_step(code_step), .code_q(dac_code), .code_moved(code_moved),
    .upd_q(code_upd)
  );
endmodule

// File: rtl/apc_loop_filter_chk.sv
module apc_loop_filter_chk #(
  parameter int CODE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              win_end,
  input logic [CODE_W-1:0] init_code,
  input logic [CODE_W-1:0] dac_code,
  input logic              code_upd
);
  localparam logic [CODE_W-1:0] TOP = '1;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |-> (dac_code == '0 && !code_upd));

  // R2
  preload_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(enable)) |-> dac_code == $past(init_code));

  // R4
  window_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(enable) && !$past(win_end)) |-> $stable(dac_code));

  // R6
  one_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(enable)) |->
      (dac_code == $past(dac_code) ||
       {1'b0, dac_code} == {1'b0, $past(dac_code)} + 1'b1 ||
       {1'b0, dac_code} + 1'b1 == {1'b0, $past(dac_code)}));

  // R7
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(enable) && $past(dac_code) == TOP) |-> dac_code != '0);

  // R9
  upd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (code_upd == (dac_code != $past(dac_code))));
endmodule

bind apc_loop_filter apc_loop_filter_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .win_end(win_end),
  .init_code(init_code), .dac_code(dac_code), .code_upd(code_upd)
);

// File: tb/test_apc_loop_filter.sv
module test_apc_loop_filter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       sample_stb = 1'b0;
  logic       fb_below = 1'b0;
  logic [3:0] ratio_sel = 4'd0;
  logic [9:0] init_code = 10'd0;
  logic [9:0] dac_code;
  logic       code_upd;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  // bench-side expectation
  int m_code = 0, m_acc = 0, m_cnt = 0, m_n = 1;
  bit m_upd = 0;

  always #2 clk = ~clk;

  apc_loop_filter i_apc_loop_filter (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sample_stb(sample_stb),
    .fb_below(fb_below), .ratio_sel(ratio_sel), .init_code(init_code),
    .dac_code(dac_code), .code_upd(code_upd)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // apply inputs, pass one edge, predict and compare
  task automatic cyc(input bit s, input bit c, input string tag);
    int prev;
    sample_stb = s;
    fb_below   = c;
    @(posedge clk);
    prev = m_code;
    if (!enable) begin
      m_code = int'(init_code); m_acc = 0; m_cnt = 0; m_n = int'(ratio_sel) + 1;
    end else if (s) begin
      m_acc += c ? 1 : -1;
      m_cnt++;
      if (m_cnt == m_n) begin
        if (m_acc > 0 && m_code < 1023) m_code++;
        else if (m_acc < 0 && m_code > 0) m_code--;
        m_acc = 0; m_cnt = 0; m_n = int'(ratio_sel) + 1;
      end
    end
    m_upd = (m_code != prev);
    #1;
    check({tag, " code"}, int'(dac_code), m_code);
    check("R9 upd", int'(code_upd), int'(m_upd));
    if (enable) begin
      checks++;
      if (int'(dac_code) - prev > 1 || prev - int'(dac_code) > 1) begin
        failures++;
        $display("FAIL R6 actual=%0d expected=%0d+-1", dac_code, prev);
      end
    end
  endtask

  task automatic start(input int pre, input int fld);
    enable = 1'b0; init_code = 10'(pre); ratio_sel = 4'(fld);
    cyc(0, 0, "R2 preload");
    enable = 1'b1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset code", int'(dac_code), 0);
    check("R1 reset upd", int'(code_upd), 0);
    rst_n = 1'b1;

    // R2: preload tracks and strobes are ignored while disabled
    init_code = 10'd300;
    cyc(0, 0, "R2 load");
    check("R2 value", int'(dac_code), 300);
    for (int i = 0; i < 6; i++) cyc(1, i[0], "R2 strobe ignored");
    check("R2 held", int'(dac_code), 300);

    // R3 R4 R5: every ratio, one-sided and balanced streams
    for (int f = 0; f < 16; f++) begin
      start(512, f);
      for (int i = 0; i < 3 * (f + 1); i++) cyc(1, 1, "R3 R4 up");
      check("R5 up three", int'(dac_code), 515);
      for (int i = 0; i < 2 * (f + 1); i++) cyc(1, 0, "R3 R4 down");
      check("R5 down two", int'(dac_code), 513);
      for (int i = 0; i < 2 * (f + 1); i++) cyc(1, i[0], "R5 alternating");
    end

    // R5: all vote patterns of a 4-strobe window
    for (int p = 0; p < 16; p++) begin
      start(200, 3);
      for (int b = 0; b < 4; b++) cyc(1, p[b], "R5 pattern");
      check("R5 pattern result", int'(dac_code),
            200 + ($countones(4'(p)) > 2 ? 1 : ($countones(4'(p)) < 2 ? -1 : 0)));
    end

    // R10: gaps without strobe, comparator toggling
    start(100, 2);
    for (int i = 0; i < 30; i++) cyc(i % 3 == 0, (i % 5) != 0, "R10 gaps");
    for (int i = 0; i < 10; i++) cyc(0, 0, "R10 idle");
    check("R10 idle low votes ignored", int'(dac_code), m_code);

    // R7: saturation at both rails
    start(1021, 0);
    for (int i = 0; i < 6; i++) cyc(1, 1, "R7 top");
    check("R7 top rail", int'(dac_code), 1023);
    start(2, 1);
    for (int i = 0; i < 10; i++) cyc(1, 0, "R7 bottom");
    check("R7 bottom rail", int'(dac_code), 0);

    // R8: ratio change mid-window
    start(400, 3);
    cyc(1, 1, "R8 pre");
    cyc(1, 1, "R8 pre");
    ratio_sel = 4'd0;
    cyc(1, 1, "R8 old window");
    check("R8 no early step", int'(dac_code), 400);
    cyc(1, 1, "R8 old window end");
    check("R8 old length", int'(dac_code), 401);
    cyc(1, 1, "R8 new length");
    check("R8 new length", int'(dac_code), 402);

    // R10: restart empty after re-enable
    start(50, 3);
    cyc(1, 1, "R10 partial"); cyc(1, 1, "R10 partial");
    start(50, 3);
    cyc(1, 0, "R10 fresh"); cyc(1, 0, "R10 fresh");
    cyc(1, 1, "R10 fresh"); cyc(1, 0, "R10 fresh");
    check("R10 restart", int'(dac_code), 49);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule